// File: doc/BRIEF.md
# Control Endpoint Sequencer

This block follows a control-read transfer on endpoint zero of a device controller. A packet decoder upstream hands it one token event per cycle: a SETUP, an IN, an OUT, or a note that the host acknowledged the last IN data packet. For each SETUP, IN or OUT token the block answers with an ACK or NAK decision. It also keeps three endpoint flags, a byte counter and a small transmit byte buffer that the CPU fills.

The transfer runs through three stages. A SETUP token opens the data stage. In the data stage the CPU loads bytes and commits a packet by clearing the transmit-ready flag. The host then reads that packet with IN tokens and acknowledges it. The first OUT token marks the status stage. That token is refused with a NAK and any unsent data is thrown away. The host retries the OUT, and the block accepts it and goes back to waiting for the next SETUP. A SETUP is always accepted, in any stage, and it wipes the endpoint state.

The CPU reaches the block through a small write port. Address 0 holds the flags, and writing 0 to a flag bit clears that flag. Address 1 holds the interrupt enables. Address 2 pushes one data byte. Token kinds, register addresses and flag bit positions are listed in the requirements.

Top module: `ep0_ctrl_seq`

## Requirements
- R1: A SETUP token (tok_kind 0) is answered with ACK in any stage, and the block enters the data stage. The handshake is hs_valid=1 with hs_ack=1 for ACK and hs_ack=0 for NAK.
- R2: A SETUP clears the transmit-ready flag (bit 0) and the received-OUT flag (bit 1), and sets the received-SETUP flag (bit 2). It also zeroes byte_cnt and pulses fifo_rst for one cycle. One cycle later the transmit-ready flag is set again.
- R3: An IN token (tok_kind 1) is refused with NAK while the transmit-ready flag is 1, and in any stage other than the data stage.
- R4: In the data stage, writing address 0 with bit 0 = 0 clears the transmit-ready flag and commits the packet. A following IN is then ACKed. A host-ack event (tok_kind 3) after that IN sets the transmit-ready flag and zeroes byte_cnt. A host-ack event never produces a handshake.
- R5: A write to address 2 stores cpu_wdata at buffer index byte_cnt and increments byte_cnt. This happens only in the data stage with the transmit-ready flag set, and only while byte_cnt is below DEPTH; other such writes are ignored. tx_rd_data shows the byte at tx_rd_addr one cycle later.
- R6: The first OUT token (tok_kind 2) in the data stage is answered with NAK and starts the status stage. It zeroes byte_cnt and sets the transmit-ready flag.
- R7: Outside the data stage, a CPU clear of the transmit-ready flag has no effect.
- R8: A second OUT in the status stage is ACKed. It sets the received-OUT and transmit-ready flags, zeroes byte_cnt, and returns the block to the idle stage, where IN and OUT tokens get NAK.
- R9: At address 0, a 1 bit leaves its flag unchanged and a 0 bit clears it. A hardware set wins over a CPU clear in the same cycle.
- R10: Address 1 bits [2:0] enable the interrupt for flags [2:0]. irq is 1 one cycle after any flag is set together with its enable bit.
- R11: After reset all flags, byte_cnt, irq, fifo_rst and hs_valid are 0, and the block is in the idle stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Token event present this cycle |
| tok_kind | input | 2 | 0 SETUP, 1 IN, 2 OUT, 3 host-ack of IN data |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 2 | 0 flags, 1 enables, 2 data byte |
| cpu_wdata | input | DW | CPU write data |
| tx_rd_addr | input | $clog2(DEPTH) | Transmit buffer read index |
| tx_rd_data | output | DW | Transmit buffer byte, one cycle after address |
| hs_valid | output | 1 | Handshake decision present |
| hs_ack | output | 1 | 1 ACK, 0 NAK |
| flag_txrdy | output | 1 | Transmit-ready flag (bit 0) |
| flag_rxout | output | 1 | Received-OUT flag (bit 1) |
| flag_rxsetup | output | 1 | Received-SETUP flag (bit 2) |
| irq | output | 1 | Interrupt request |
| byte_cnt | output | $clog2(DEPTH+1) | Bytes held in the transmit buffer |
| fifo_rst | output | 1 | One-cycle buffer reset pulse on SETUP |

## Verification
The handshake, the flags, byte_cnt and fifo_rst all change at the first rising edge after the token or CPU write. There are two exceptions. The transmit-ready flag comes back one edge later after a SETUP. irq trails its flag or enable by one more edge. The buffer read data is due one edge after the address. The bench drives every input on a falling edge and samples at the next falling edge, so each result is read half a period after the edge that produced it. Checks on the delayed results wait the extra cycles before sampling.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;
  typedef enum logic [1:0] {
    TK_SETUP = 2'd0,
    TK_IN    = 2'd1,
    TK_OUT   = 2'd2,
    TK_HACK  = 2'd3
  } tok_kind_e;

  typedef enum logic [1:0] {
    STG_IDLE   = 2'd0,
    STG_DATA   = 2'd1,
    STG_STATUS = 2'd2
  } stage_e;

  localparam logic [1:0] REG_FLAGS  = 2'd0;
  localparam logic [1:0] REG_ENABLE = 2'd1;
  localparam logic [1:0] REG_DATA   = 2'd2;

  localparam int FLG_TXRDY   = 0;
  localparam int FLG_RXOUT   = 1;
  localparam int FLG_RXSETUP = 2;
  localparam int NUM_FLAGS   = 3;
endpackage

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
  import ep0_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tok_valid,
  input  logic [1:0] tok_kind,
  input  logic   txrdy,
  output stage_e stage,
  output logic   ev_setup,
  output logic   ev_status_det,
  output logic   ev_status_ack,
  output logic   ev_host_ack,
  output logic   hs_valid,
  output logic   hs_ack
);
  tok_kind_e kind;
  logic      in_send;
  logic      sent_q;
  stage_e    stage_d;

  always_comb begin
    kind          = tok_kind_e'(tok_kind);
    ev_setup      = tok_valid && kind == TK_SETUP;
    ev_status_det = tok_valid && kind == TK_OUT && stage == STG_DATA;
    ev_status_ack = tok_valid && kind == TK_OUT && stage == STG_STATUS;
    in_send       = tok_valid && kind == TK_IN && stage == STG_DATA && !txrdy;
    ev_host_ack   = tok_valid && kind == TK_HACK && stage == STG_DATA && sent_q;
  end

  always_comb begin
    stage_d = stage;
    if (ev_setup)           stage_d = STG_DATA;
    else if (ev_status_det) stage_d = STG_STATUS;
    else if (ev_status_ack) stage_d = STG_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage    <= STG_IDLE;
      sent_q   <= 1'b0;
      hs_valid <= 1'b0;
      hs_ack   <= 1'b0;
    end else begin
      stage    <= stage_d;
      hs_valid <= tok_valid && kind != TK_HACK;
      hs_ack   <= ev_setup || in_send || ev_status_ack;
      if (ev_setup || ev_status_det || ev_host_ack) sent_q <= 1'b0;
      else if (in_send)                             sent_q <= 1'b1;
    end
  end

  // R1
  setup_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_kind == TK_SETUP) |=> (hs_valid && hs_ack && stage == STG_DATA));

  // R3
  in_nak_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_kind == TK_IN && txrdy) |=> (hs_valid && !hs_ack));

  // R6
  status_first_nak_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_kind == TK_OUT && stage == STG_DATA) |=> (hs_valid && !hs_ack && stage == STG_STATUS));
endmodule

// File: rtl/ep0_flag_bank.sv
module ep0_flag_bank
  import ep0_seq_pkg::*;
#(
  parameter int NF = NUM_FLAGS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          data_stage,
  input  logic          ev_setup,
  input  logic          ev_status_det,
  input  logic          ev_status_ack,
  input  logic          ev_host_ack,
  input  logic          flag_wr,
  input  logic          en_wr,
  input  logic [NF-1:0] wbits,
  output logic [NF-1:0] flags,
  output logic          irq
);
  logic [NF-1:0] set_v, kill_v, clr_v, en_q;
  logic          setup_d;

  always_comb begin
    set_v  = '0;
    kill_v = '0;
    set_v[FLG_TXRDY]   = setup_d || ev_status_det || ev_status_ack || ev_host_ack;
    set_v[FLG_RXOUT]   = ev_status_ack;
    set_v[FLG_RXSETUP] = ev_setup;
    kill_v[FLG_TXRDY]  = ev_setup;
    kill_v[FLG_RXOUT]  = ev_setup;
  end

  for (genvar i = 0; i < NF; i++) begin : g_flag
    if (i == FLG_TXRDY) begin : g_gated
      assign clr_v[i] = flag_wr && !wbits[i] && data_stage;
    end else begin : g_free
      assign clr_v[i] = flag_wr && !wbits[i];
    end

    always_ff @(posedge clk) begin
      if (rst)            flags[i] <= 1'b0;
      else if (kill_v[i]) flags[i] <= 1'b0;
      else if (set_v[i])  flags[i] <= 1'b1;
      else if (clr_v[i])  flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      irq     <= 1'b0;
      setup_d <= 1'b0;
    end else begin
      setup_d <= ev_setup;
      irq     <= |(flags & en_q);
      if (en_wr) en_q <= wbits;
    end
  end

  // R2
  setup_flags_chk: assert property (@(posedge clk) disable iff (rst)
    ev_setup |=> (flags[FLG_RXSETUP] && !flags[FLG_RXOUT] && !flags[FLG_TXRDY]));

  // R7
  txrdy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flags[FLG_TXRDY] && !data_stage && !ev_setup) |=> flags[FLG_TXRDY]);

  // R8
  status_ack_flags_chk: assert property (@(posedge clk) disable iff (rst)
    ev_status_ack |=> (flags[FLG_RXOUT] && flags[FLG_TXRDY]));
endmodule

// File: rtl/ep0_tx_buffer.sv
module ep0_tx_buffer #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          setup,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic          fifo_rst
);
  logic [DW-1:0] mem [DEPTH];
  logic          do_wr;

  assign do_wr = wr_req && !clear && (count < CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (do_wr) mem[count[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      fifo_rst <= 1'b0;
    end else begin
      fifo_rst <= setup;
      if (clear)      count <= '0;
      else if (do_wr) count <= count + 1'b1;
    end
  end

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R2
  fifo_rst_empty_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_rst |-> (count == '0));
endmodule

// File: rtl/ep0_ctrl_seq.sv
module ep0_ctrl_seq
  import ep0_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tok_valid,
  input  logic [1:0]    tok_kind,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [AW-1:0] tx_rd_addr,
  output logic [DW-1:0] tx_rd_data,
  output logic          hs_valid,
  output logic          hs_ack,
  output logic          flag_txrdy,
  output logic          flag_rxout,
  output logic          flag_rxsetup,
  output logic          irq,
  output logic [CW-1:0] byte_cnt,
  output logic          fifo_rst
);
  stage_e               stage;
  logic                 ev_setup, ev_status_det, ev_status_ack, ev_host_ack;
  logic [NUM_FLAGS-1:0] flags;
  logic                 data_stage;
  logic                 flag_wr, en_wr, data_wr, buf_clear;

  assign data_stage = (stage == STG_DATA);
  assign flag_wr    = cpu_wr && cpu_addr == REG_FLAGS;
  assign en_wr      = cpu_wr && cpu_addr == REG_ENABLE;
  assign data_wr    = cpu_wr && cpu_addr == REG_DATA && data_stage && flags[FLG_TXRDY];
  assign buf_clear  = ev_setup || ev_status_det || ev_status_ack || ev_host_ack;

  ep0_stage_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .tok_valid     (tok_valid),
    .tok_kind      (tok_kind),
    .txrdy         (flags[FLG_TXRDY]),
    .stage         (stage),
    .ev_setup      (ev_setup),
    .ev_status_det (ev_status_det),
    .ev_status_ack (ev_status_ack),
    .ev_host_ack   (ev_host_ack),
    .hs_valid      (hs_valid),
    .hs_ack        (hs_ack)
  );

  ep0_flag_bank #(.NF(NUM_FLAGS)) u_flags (
    .clk           (clk),
    .rst           (rst),
    .data_stage    (data_stage),
    .ev_setup      (ev_setup),
    .ev_status_det (ev_status_det),
    .ev_status_ack (ev_status_ack),
    .ev_host_ack   (ev_host_ack),
    .flag_wr       (flag_wr),
    .en_wr         (en_wr),
    .wbits         (cpu_wdata[NUM_FLAGS-1:0]),
    .flags         (flags),
    .irq           (irq)
  );

  ep0_tx_buffer #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .clear    (buf_clear),
    .setup    (ev_setup),
    .wr_req   (data_wr),
    .wr_data  (cpu_wdata),
    .rd_addr  (tx_rd_addr),
    .rd_data  (tx_rd_data),
    .count    (byte_cnt),
    .fifo_rst (fifo_rst)
  );

  assign flag_txrdy   = flags[FLG_TXRDY];
  assign flag_rxout   = flags[FLG_RXOUT];
  assign flag_rxsetup = flags[FLG_RXSETUP];
endmodule

// File: tb/sim_ep0_ctrl_seq.sv
module sim_ep0_ctrl_seq;
  localparam int DEPTH = 64;
  localparam int DW    = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NV    = 22;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tok_valid = 1'b0;
  logic [1:0]    tok_kind = 2'd0;
  logic          cpu_wr = 1'b0;
  logic [1:0]    cpu_addr = 2'd0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [AW-1:0] tx_rd_addr = '0;
  logic [DW-1:0] tx_rd_data;
  logic          hs_valid, hs_ack, flag_txrdy, flag_rxout, flag_rxsetup, irq, fifo_rst;
  logic [CW-1:0] byte_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ep0_ctrl_seq #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .tx_rd_addr(tx_rd_addr), .tx_rd_data(tx_rd_data),
    .hs_valid(hs_valid), .hs_ack(hs_ack), .flag_txrdy(flag_txrdy),
    .flag_rxout(flag_rxout), .flag_rxsetup(flag_rxsetup), .irq(irq),
    .byte_cnt(byte_cnt), .fifo_rst(fifo_rst)
  );

  // {req[3:0], tv, kind[1:0], cw, ca[1:0], cd[7:0], hv, ha, txrdy, rxout, rxsetup, cnt[7:0]}
  localparam logic [30:0] VEC [NV] = '{
    {4'd1, 1'b1,2'd0, 1'b0,2'd0,8'h00, 1'b1,1'b1,1'b0,1'b0,1'b1, 8'd0}, // R1 setup acked
    {4'd2, 1'b0,2'd0, 1'b0,2'd0,8'h00, 1'b0,1'b0,1'b1,1'b0,1'b1, 8'd0}, // R2 txrdy back
    {4'd3, 1'b1,2'd1, 1'b0,2'd0,8'h00, 1'b1,1'b0,1'b1,1'b0,1'b1, 8'd0}, // R3 IN before commit
    {4'd9, 1'b0,2'd0, 1'b1,2'd0,8'h03, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'd0}, // R9 clear rxsetup only
    {4'd5, 1'b0,2'd0, 1'b1,2'd2,8'hAA, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'd1}, // R5
    {4'd5, 1'b0,2'd0, 1'b1,2'd2,8'hBB, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'd2}, // R5
    {4'd5, 1'b0,2'd0, 1'b1,2'd2,8'hCC, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'd3}, // R5
    {4'd4, 1'b0,2'd0, 1'b1,2'd0,8'h06, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'd3}, // R4 commit
    {4'd5, 1'b0,2'd0, 1'b1,2'd2,8'hDD, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'd3}, // R5 write ignored
    {4'd4, 1'b1,2'd1, 1'b0,2'd0,8'h00, 1'b1,1'b1,1'b0,1'b0,1'b0, 8'd3}, // R4 IN sent
    {4'd4, 1'b1,2'd3, 1'b0,2'd0,8'h00, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'd0}, // R4 host ack
    {4'd5, 1'b0,2'd0, 1'b1,2'd2,8'h11, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'd1}, // R5
    {4'd6, 1'b1,2'd2, 1'b0,2'd0,8'h00, 1'b1,1'b0,1'b1,1'b0,1'b0, 8'd0}, // R6 status NAK
    {4'd7, 1'b0,2'd0, 1'b1,2'd0,8'h00, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'd0}, // R7 clear ignored
    {4'd5, 1'b0,2'd0, 1'b1,2'd2,8'h22, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'd0}, // R5 no write in status
    {4'd3, 1'b1,2'd1, 1'b0,2'd0,8'h00, 1'b1,1'b0,1'b1,1'b0,1'b0, 8'd0}, // R3 IN in status
    {4'd8, 1'b1,2'd2, 1'b1,2'd0,8'h00, 1'b1,1'b1,1'b1,1'b1,1'b0, 8'd0}, // R8 R9 retry acked
    {4'd8, 1'b1,2'd2, 1'b0,2'd0,8'h00, 1'b1,1'b0,1'b1,1'b1,1'b0, 8'd0}, // R8 OUT idle NAK
    {4'd7, 1'b0,2'd0, 1'b1,2'd0,8'h04, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'd0}, // R7 R9 idle clear
    {4'd8, 1'b1,2'd1, 1'b0,2'd0,8'h00, 1'b1,1'b0,1'b1,1'b0,1'b0, 8'd0}, // R8 IN idle NAK
    {4'd4, 1'b1,2'd3, 1'b0,2'd0,8'h00, 1'b0,1'b0,1'b1,1'b0,1'b0, 8'd0}, // R4 stray host ack
    {4'd1, 1'b1,2'd0, 1'b0,2'd0,8'h00, 1'b1,1'b1,1'b0,1'b0,1'b1, 8'd0}  // R1 new setup
  };

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic drive(input bit tv, input logic [1:0] k, input bit cw, input logic [1:0] ca, input logic [7:0] cd);
    tok_valid = tv; tok_kind = k; cpu_wr = cw; cpu_addr = ca; cpu_wdata = cd;
    @(negedge clk);
    tok_valid = 1'b0; cpu_wr = 1'b0;
  endtask

  function automatic logic [12:0] obs();
    return {hs_valid, hs_ack, flag_txrdy, flag_rxout, flag_rxsetup, 8'(byte_cnt)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk({hs_valid, flag_txrdy, flag_rxout, flag_rxsetup, irq, fifo_rst} == '0 && byte_cnt == '0,
        "R11 reset state", {hs_valid, flag_txrdy, flag_rxout, flag_rxsetup, irq, fifo_rst, 8'(byte_cnt)}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][26], VEC[i][25:24], VEC[i][23], VEC[i][22:21], VEC[i][20:13]);
      chk(obs() == VEC[i][12:0], $sformatf("table step %0d R%0d", i, VEC[i][30:27]),
          32'(obs()), 32'(VEC[i][12:0]));
    end

    // R10 irq follows enabled rxsetup one cycle late
    drive(1'b0, 2'd0, 1'b1, 2'd1, 8'h04);
    chk(irq == 1'b0, "R10 irq not yet", 32'(irq), 32'd0);
    drive(1'b0, 2'd0, 1'b0, 2'd0, 8'h00);
    chk(irq == 1'b1, "R10 irq raised", 32'(irq), 32'd1);
    drive(1'b0, 2'd0, 1'b1, 2'd1, 8'h00);
    drive(1'b0, 2'd0, 1'b0, 2'd0, 8'h00);
    chk(irq == 1'b0, "R10 irq dropped", 32'(irq), 32'd0);

    // R5 buffer contents and read latency
    drive(1'b0, 2'd0, 1'b1, 2'd2, 8'h5A);
    drive(1'b0, 2'd0, 1'b1, 2'd2, 8'hA5);
    drive(1'b0, 2'd0, 1'b1, 2'd2, 8'h3C);
    chk(byte_cnt == CW'(3), "R5 count after three", 32'(byte_cnt), 32'd3);
    tx_rd_addr = AW'(1);
    @(negedge clk);
    chk(tx_rd_data == 8'hA5, "R5 readback index 1", 32'(tx_rd_data), 32'hA5);
    tx_rd_addr = AW'(2);
    @(negedge clk);
    chk(tx_rd_data == 8'h3C, "R5 readback index 2", 32'(tx_rd_data), 32'h3C);

    // R5 saturation at DEPTH
    for (int j = 0; j < DEPTH + 6; j++) drive(1'b0, 2'd0, 1'b1, 2'd2, 8'(j));
    chk(byte_cnt == CW'(DEPTH), "R5 count saturates", 32'(byte_cnt), 32'(DEPTH));

    // R2 SETUP in mid data stage resets the buffer
    drive(1'b1, 2'd0, 1'b0, 2'd0, 8'h00);
    chk(fifo_rst && byte_cnt == '0 && !flag_txrdy && hs_ack, "R2 setup mid data",
        {fifo_rst, hs_ack, flag_txrdy, 8'(byte_cnt)}, 32'h600);
    drive(1'b0, 2'd0, 1'b0, 2'd0, 8'h00);
    chk(!fifo_rst && flag_txrdy, "R2 pulse ends, txrdy back", {fifo_rst, flag_txrdy}, 32'h1);

    // R9 hardware set of rxsetup beats same-cycle clear
    drive(1'b0, 2'd0, 1'b1, 2'd0, 8'h03);
    drive(1'b1, 2'd0, 1'b1, 2'd0, 8'h00);
    chk(flag_rxsetup && hs_valid && hs_ack, "R9 set beats clear",
        {flag_rxsetup, hs_valid, hs_ack}, 32'h7);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=%h exp=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule